// File: doc/BRIEF.md
# Two-Wire Slave Bus Front-End

This block is the slave side of a two-wire serial bus, built for a small register target such as a digital trimmer controller. It samples the clock line and the data line with a fast system clock and finds the bus START and STOP events in those samples. It then receives an 8-bit address byte and an instruction byte. After that it either takes in one data byte or sends read bytes out. The block only acknowledges or drives the data line low. It never drives the line high, so a pull-up sets the line level when nobody pulls it low.

The decoded instruction fields, the received data byte and a request for each outgoing read byte go to a separate command executor. The executor reports a nonvolatile programming cycle through `busy_i`. While that input is high, the block does not acknowledge its own address, so a master can poll for completion. An active-low protect input stops writes to the stored-setting registers. When it is low, the block still acknowledges the address and instruction bytes of such a write but refuses the data byte.

Top module: `twi_slave_front`

## Requirements
- R1: A START (data falling while clock is high) in any state, including in the middle of a byte, restarts address reception. A STOP (data rising while clock is high) ends the transaction and releases the data line. After a STOP, no byte is acknowledged until the next START.
- R2: The address byte is acknowledged by pulling the data line low during the ninth clock only when its upper nibble is 0101 and its lower nibble equals `strap_i`. Otherwise nothing more is acknowledged or strobed until the next START.
- R3: The block changes its drive of the data line only while the clock line is low.
- R4: While `busy_i` is high, a matching address is not acknowledged. Once `busy_i` is low, the same address is acknowledged again.
- R5: Every instruction byte that follows an acknowledged address is acknowledged. Its bits 7:4 appear on `opcode_o`, bits 3:2 on `dreg_o` and bits 1:0 on `pot_o`, and `instr_valid_o` pulses for one cycle.
- R6: For opcodes 1010 (load wiper) and 1100 (store setting) with writes allowed, the next byte is acknowledged, appears on `data_o`, and `data_valid_o` pulses for one cycle.
- R7: For opcode 1100 with `wp_n_i` low, the address and instruction are acknowledged but the data byte is not, and `data_valid_o` stays low.
- R8: For opcodes 1001 and 1011, `rd_load_o` pulses at the falling clock edge that ends the instruction acknowledge. The byte on `rd_data_i` is then shifted out MSB first, and the line is released for the ninth clock.
- R9: If the master acknowledges a read byte, a new byte is requested and sent. If it does not, the block stops driving and ignores the bus until STOP or START.
- R10: For any other opcode, no byte after the instruction is acknowledged and no data strobe occurs.
- R11: During and right after reset, the data line is released and all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND) |
| sda_oe_o | output | 1 | Pull data line low when 1 |
| strap_i | input | 4 | Board-strapped device address |
| busy_i | input | 1 | Nonvolatile cycle in progress, address is not acknowledged |
| wp_n_i | input | 1 | Active-low protect for stored-setting writes |
| rd_data_i | input | 8 | Byte to send, taken when rd_load_o pulses |
| instr_valid_o | output | 1 | One-cycle pulse: instruction byte accepted |
| opcode_o | output | 4 | Opcode of the last instruction |
| dreg_o | output | 2 | Stored-setting register select |
| pot_o | output | 2 | Channel select |
| data_valid_o | output | 1 | One-cycle pulse: data byte accepted |
| data_o | output | 8 | Last accepted data byte |
| rd_load_o | output | 1 | One-cycle pulse: read byte taken from rd_data_i |

## Verification
A repeated START can arrive while the bit counter is partway through a byte. In that case the START must win over the shift and counting logic. The bench provokes this by clocking half an address byte and then issuing a new START, and the full transaction that follows must be acknowledged at every byte. Protect and busy checks come from random transactions with directed cases, and each acknowledge is judged at the ninth clock against the expected value computed by the bench.

// File: rtl/twi_pkg.sv
package twi_pkg;
  localparam int OP_W   = 4;
  localparam int REG_W  = 2;
  localparam int POT_W  = 2;
  localparam int BYTE_W = OP_W + REG_W + POT_W;

  typedef enum logic [2:0] {
    PH_IDLE, PH_ADDR, PH_INSTR, PH_WDATA, PH_RDATA
  } phase_t;

  localparam logic [OP_W-1:0] OP_RD_WIPER = 4'b1001;
  localparam logic [OP_W-1:0] OP_LD_WIPER = 4'b1010;
  localparam logic [OP_W-1:0] OP_RD_STORE = 4'b1011;
  localparam logic [OP_W-1:0] OP_WR_STORE = 4'b1100;

  function automatic logic op_is_read(input logic [OP_W-1:0] op);
    return (op == OP_RD_WIPER) || (op == OP_RD_STORE);
  endfunction

  function automatic logic op_has_data(input logic [OP_W-1:0] op);
    return (op == OP_LD_WIPER) || (op == OP_WR_STORE);
  endfunction

  function automatic logic op_is_guarded(input logic [OP_W-1:0] op);
    return op == OP_WR_STORE;
  endfunction
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_p, sda_p;

  generate
    if (STAGES < 2) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_q <= '1;
          sda_q <= '1;
        end else begin
          scl_q <= scl_i;
          sda_q <= sda_i;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_q <= '1;
          sda_q <= '1;
        end else begin
          scl_q <= {scl_q[STAGES-2:0], scl_i};
          sda_q <= {sda_q[STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_q[STAGES-1];
      sda_p <= sda_q[STAGES-1];
    end
  end

  assign scl_o      = scl_q[STAGES-1];
  assign sda_o      = sda_q[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_p;
  assign scl_fall_o = ~scl_o & scl_p;
  assign start_o    = scl_o & scl_p & sda_p & ~sda_o;
  assign stop_o     = scl_o & scl_p & ~sda_p & sda_o;
endmodule

// File: rtl/twi_shift_unit.sv
module twi_shift_unit #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_in_en,
  input  logic         bit_in,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  input  logic         shift_out_en,
  output logic [W-1:0] rx_byte,
  output logic         tx_next
);
  // The MSB goes straight to the line when loaded; only the rest is held.
  logic [W-2:0] tx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_byte <= '0;
      tx_q    <= '0;
    end else begin
      if (shift_in_en) rx_byte <= {rx_byte[W-2:0], bit_in};
      if (load_en)
        tx_q <= load_val[W-2:0];
      else if (shift_out_en)
        tx_q <= {tx_q[W-3:0], 1'b0};
    end
  end

  assign tx_next = tx_q[W-2];
endmodule

// File: rtl/twi_bus_ctrl.sv
module twi_bus_ctrl
  import twi_pkg::*;
#(
  parameter int                        STRAP_W = 4,
  parameter logic [BYTE_W-STRAP_W-1:0] TYPE_ID = 4'b0101
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sda_lvl,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               start_det,
  input  logic               stop_det,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               busy_i,
  input  logic               wp_n_i,
  input  logic               rd_msb,
  input  logic [BYTE_W-1:0]  rx_byte,
  input  logic               tx_next,
  output logic               rx_shift_en,
  output logic               tx_load_en,
  output logic               tx_shift_en,
  output logic               sda_oe_o,
  output logic               instr_valid_o,
  output logic [OP_W-1:0]    opcode_o,
  output logic [REG_W-1:0]   dreg_o,
  output logic [POT_W-1:0]   pot_o,
  output logic               data_valid_o,
  output logic [BYTE_W-1:0]  data_o,
  output logic               rd_load_o
);
  localparam int CNT_W = $clog2(BYTE_W + 2);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_W + 1);

  phase_t           phase, next_ph;
  logic [CNT_W-1:0] bitcnt;
  logic             mack;
  logic             receiving, slot_end, addr_hit;
  logic [OP_W-1:0]  rx_op;

  assign addr_hit = (rx_byte[BYTE_W-1:STRAP_W] == TYPE_ID) &&
                    (rx_byte[STRAP_W-1:0] == strap_i);
  assign rx_op    = rx_byte[BYTE_W-1 -: OP_W];

  always_comb begin
    receiving   = (phase == PH_ADDR) || (phase == PH_INSTR) || (phase == PH_WDATA);
    rx_shift_en = scl_rise && receiving && (bitcnt < LAST_BIT);
    slot_end    = scl_fall && (bitcnt == ACK_SLOT) && (phase != PH_IDLE);
    tx_load_en  = slot_end && (next_ph == PH_RDATA) && ((phase != PH_RDATA) || mack);
    tx_shift_en = scl_fall && (phase == PH_RDATA) && (bitcnt != '0) && (bitcnt < LAST_BIT);
  end

  always_ff @(posedge clk) begin
    instr_valid_o <= 1'b0;
    data_valid_o  <= 1'b0;
    rd_load_o     <= 1'b0;
    if (rst) begin
      phase    <= PH_IDLE;
      next_ph  <= PH_IDLE;
      bitcnt   <= '0;
      mack     <= 1'b0;
      sda_oe_o <= 1'b0;
      opcode_o <= '0;
      dreg_o   <= '0;
      pot_o    <= '0;
      data_o   <= '0;
    end else if (start_det) begin
      phase    <= PH_ADDR;
      bitcnt   <= '0;
      sda_oe_o <= 1'b0;
    end else if (stop_det) begin
      phase    <= PH_IDLE;
      bitcnt   <= '0;
      sda_oe_o <= 1'b0;
    end else if (phase != PH_IDLE) begin
      if (scl_rise) begin
        if (bitcnt < LAST_BIT) bitcnt <= bitcnt + 1'b1;
        else if (bitcnt == ACK_SLOT) mack <= ~sda_lvl;
      end else if (scl_fall) begin
        if (bitcnt == LAST_BIT) begin
          bitcnt <= ACK_SLOT;
          case (phase)
            PH_ADDR: begin
              if (addr_hit && !busy_i) begin
                sda_oe_o <= 1'b1;
                next_ph  <= PH_INSTR;
              end else begin
                phase <= PH_IDLE;
              end
            end
            PH_INSTR: begin
              sda_oe_o      <= 1'b1;
              instr_valid_o <= 1'b1;
              opcode_o      <= rx_op;
              dreg_o        <= rx_byte[POT_W +: REG_W];
              pot_o         <= rx_byte[POT_W-1:0];
              next_ph       <= op_is_read(rx_op)  ? PH_RDATA :
                               op_has_data(rx_op) ? PH_WDATA : PH_IDLE;
            end
            PH_WDATA: begin
              if (op_is_guarded(opcode_o) && !wp_n_i) begin
                phase <= PH_IDLE;
              end else begin
                sda_oe_o     <= 1'b1;
                data_valid_o <= 1'b1;
                data_o       <= rx_byte;
                next_ph      <= PH_IDLE;
              end
            end
            PH_RDATA: begin
              sda_oe_o <= 1'b0;
              next_ph  <= PH_RDATA;
            end
            default: phase <= PH_IDLE;
          endcase
        end else if (slot_end) begin
          bitcnt <= '0;
          if (tx_load_en) begin
            sda_oe_o  <= ~rd_msb;
            rd_load_o <= 1'b1;
            phase     <= PH_RDATA;
          end else begin
            sda_oe_o <= 1'b0;
            phase    <= (phase == PH_RDATA) ? PH_IDLE : next_ph;
          end
        end else if (tx_shift_en) begin
          sda_oe_o <= ~tx_next;
        end
      end
    end
  end
endmodule

// File: rtl/twi_slave_front.sv
module twi_slave_front
  import twi_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int STRAP_W     = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe_o,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               busy_i,
  input  logic               wp_n_i,
  input  logic [BYTE_W-1:0]  rd_data_i,
  output logic               instr_valid_o,
  output logic [OP_W-1:0]    opcode_o,
  output logic [REG_W-1:0]   dreg_o,
  output logic [POT_W-1:0]   pot_o,
  output logic               data_valid_o,
  output logic [BYTE_W-1:0]  data_o,
  output logic               rd_load_o
);
  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic rx_shift_en, tx_load_en, tx_shift_en, tx_next;
  logic [BYTE_W-1:0] rx_byte;

  twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_o(scl_lvl), .sda_o(sda_lvl), .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall), .start_o(start_det), .stop_o(stop_det)
  );

  twi_shift_unit #(.W(BYTE_W)) u_shift (
    .clk(clk), .rst(rst), .shift_in_en(rx_shift_en), .bit_in(sda_lvl),
    .load_en(tx_load_en), .load_val(rd_data_i), .shift_out_en(tx_shift_en),
    .rx_byte(rx_byte), .tx_next(tx_next)
  );

  twi_bus_ctrl #(.STRAP_W(STRAP_W)) u_ctrl (
    .clk(clk), .rst(rst), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .strap_i(strap_i), .busy_i(busy_i), .wp_n_i(wp_n_i),
    .rd_msb(rd_data_i[BYTE_W-1]), .rx_byte(rx_byte), .tx_next(tx_next),
    .rx_shift_en(rx_shift_en), .tx_load_en(tx_load_en), .tx_shift_en(tx_shift_en),
    .sda_oe_o(sda_oe_o), .instr_valid_o(instr_valid_o), .opcode_o(opcode_o),
    .dreg_o(dreg_o), .pot_o(pot_o), .data_valid_o(data_valid_o),
    .data_o(data_o), .rd_load_o(rd_load_o)
  );
endmodule

// File: rtl/twi_slave_front_chk.sv
module twi_slave_front_chk (
  input logic       clk,
  input logic       rst,
  input logic       scl_lvl,
  input logic       start_det,
  input logic       stop_det,
  input logic       sda_oe_o,
  input logic       instr_valid_o,
  input logic       data_valid_o,
  input logic       rd_load_o,
  input logic [3:0] opcode_o,
  input logic       wp_n_i
);
  // R1: a START releases the line on the next cycle
  a_r1_start_releases: assert property (@(posedge clk) disable iff (rst)
    start_det |=> !sda_oe_o);

  // R1: a STOP releases the line on the next cycle
  a_r1_stop_releases: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_oe_o);

  // R3: drive changes only while the sampled clock line is low
  a_r3_drive_moves_scl_low: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe_o) |-> !scl_lvl);

  // R5: instruction strobe lasts one cycle
  a_r5_instr_one_cycle: assert property (@(posedge clk) disable iff (rst)
    instr_valid_o |=> !instr_valid_o);

  // R6: instruction and data strobes come from different bytes
  a_r6_strobes_apart: assert property (@(posedge clk) disable iff (rst)
    !(instr_valid_o && data_valid_o));

  // R7: a stored-setting data strobe requires writes to have been allowed
  a_r7_guarded_needs_wp: assert property (@(posedge clk) disable iff (rst)
    (data_valid_o && opcode_o == 4'b1100) |-> $past(wp_n_i));

  // R8: a read request is never paired with a write-data strobe
  a_r8_load_alone: assert property (@(posedge clk) disable iff (rst)
    rd_load_o |-> !data_valid_o && !instr_valid_o);
endmodule

bind twi_slave_front twi_slave_front_chk u_chk (
  .clk(clk), .rst(rst), .scl_lvl(scl_lvl), .start_det(start_det),
  .stop_det(stop_det), .sda_oe_o(sda_oe_o), .instr_valid_o(instr_valid_o),
  .data_valid_o(data_valid_o), .rd_load_o(rd_load_o), .opcode_o(opcode_o),
  .wp_n_i(wp_n_i)
);

// File: tb/twi_slave_front_tb_top.sv
module twi_slave_front_tb_top;
  localparam int HP = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic m_scl = 1'b1, m_sda = 1'b1;
  logic [3:0] strap = 4'h0;
  logic busy = 1'b0, wp_n = 1'b1;
  logic [7:0] rd_base = 8'h00;
  logic [7:0] rd_data;
  wire  sda_oe;
  wire  sda_bus = m_sda & ~sda_oe;
  logic instr_valid, data_valid, rd_load;
  logic [3:0] opcode;
  logic [1:0] dreg, pot;
  logic [7:0] data;

  int n_instr = 0, n_data = 0, n_load = 0;
  int checks = 0, failures = 0, unstable = 0;

  assign rd_data = rd_base + n_load[7:0];

  twi_slave_front dut_i (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe_o(sda_oe),
    .strap_i(strap), .busy_i(busy), .wp_n_i(wp_n), .rd_data_i(rd_data),
    .instr_valid_o(instr_valid), .opcode_o(opcode), .dreg_o(dreg), .pot_o(pot),
    .data_valid_o(data_valid), .data_o(data), .rd_load_o(rd_load)
  );

  always @(negedge clk) begin
    if (instr_valid) n_instr++;
    if (data_valid)  n_data++;
    if (rd_load)     n_load++;
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wt(HP);
    m_scl = 1'b1; wt(HP);
    m_sda = 1'b0; wt(HP);
    m_scl = 1'b0; wt(HP);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wt(HP);
    m_scl = 1'b1; wt(HP);
    m_sda = 1'b1; wt(HP);
  endtask

  task automatic clk_bit(input logic b, output logic seen);
    logic early;
    m_sda = b; wt(HP);
    m_scl = 1'b1; wt(2);
    early = sda_bus; wt(HP - 4);
    seen = sda_bus;
    if (early != seen) unstable++;
    wt(2);
    m_scl = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      b[i] = s;
    end
    clk_bit(~mack, s);
  endtask

  task automatic xfer3(input logic [7:0] a, input logic [7:0] ins, input logic [7:0] d,
                       output logic ka, output logic ki, output logic kd);
    bus_start();
    send_byte(a, ka);
    send_byte(ins, ki);
    send_byte(d, kd);
    bus_stop();
  endtask

  function automatic logic exp_data_ack(input logic [3:0] op, input logic wpn);
    if (op == 4'b1010) return 1'b1;
    if (op == 4'b1100) return wpn;
    return 1'b0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic ka, ki, kd;
    logic [7:0] addr, ins, d, rb;
    int snap_i, snap_d, snap_l;
    int seed;
    seed = $urandom(32'd4711);

    // R11: reset state
    wt(6);
    check("R11 line released in reset", int'(sda_oe), 0);
    check("R11 strobes low in reset", int'(instr_valid | data_valid | rd_load), 0);
    rst = 1'b0;
    wt(4);
    check("R11 line released after reset", int'(sda_oe), 0);

    // R2/R5/R6: directed matching write
    strap = 4'hB;
    snap_i = n_instr; snap_d = n_data;
    xfer3({4'b0101, 4'hB}, {4'b1010, 2'b01, 2'b10}, 8'hC3, ka, ki, kd);
    check("R2 address ack", int'(ka), 1);
    check("R5 instruction ack", int'(ki), 1);
    check("R6 data ack", int'(kd), 1);
    check("R5 opcode field", int'(opcode), 4'b1010);
    check("R5 register field", int'(dreg), 2'b01);
    check("R5 channel field", int'(pot), 2'b10);
    check("R5 one instruction strobe", n_instr - snap_i, 1);
    check("R6 data value", int'(data), 8'hC3);
    check("R6 one data strobe", n_data - snap_d, 1);
    check("R1 released after STOP", int'(sda_oe), 0);

    // R2: strap mismatch and wrong type nibble
    snap_i = n_instr; snap_d = n_data;
    xfer3({4'b0101, 4'hA}, 8'hA0, 8'h11, ka, ki, kd);
    check("R2 strap mismatch address nack", int'(ka), 0);
    check("R2 mismatch instruction nack", int'(ki), 0);
    check("R2 mismatch data nack", int'(kd), 0);
    xfer3({4'b1101, 4'hB}, 8'hA0, 8'h11, ka, ki, kd);
    check("R2 type mismatch address nack", int'(ka), 0);
    check("R2 mismatch no strobes", (n_instr - snap_i) + (n_data - snap_d), 0);

    // R7: protected stored-setting write
    wp_n = 1'b0;
    snap_d = n_data;
    xfer3({4'b0101, 4'hB}, {4'b1100, 2'b11, 2'b01}, 8'h5E, ka, ki, kd);
    check("R7 address ack under protect", int'(ka), 1);
    check("R7 instruction ack under protect", int'(ki), 1);
    check("R7 data nack under protect", int'(kd), 0);
    check("R7 no data strobe under protect", n_data - snap_d, 0);
    // R6: wiper load still accepted while protected
    xfer3({4'b0101, 4'hB}, {4'b1010, 2'b00, 2'b01}, 8'h77, ka, ki, kd);
    check("R6 wiper load ack under protect", int'(kd), 1);
    check("R6 wiper load value", int'(data), 8'h77);
    wp_n = 1'b1;

    // R4: busy polling
    busy = 1'b1;
    bus_start(); send_byte({4'b0101, 4'hB}, ka); bus_stop();
    check("R4 address nack while busy", int'(ka), 0);
    busy = 1'b0;
    bus_start(); send_byte({4'b0101, 4'hB}, ka); bus_stop();
    check("R4 address ack after busy", int'(ka), 1);

    // R10: other opcode takes no data byte
    snap_d = n_data;
    xfer3({4'b0101, 4'hB}, {4'b1101, 2'b10, 2'b01}, 8'h3C, ka, ki, kd);
    check("R10 instruction ack", int'(ki), 1);
    check("R10 trailing byte nack", int'(kd), 0);
    check("R10 no data strobe", n_data - snap_d, 0);

    // R8/R9: read three bytes, then no-ack and released line
    rd_base = 8'h5A;
    snap_l = n_load;
    bus_start();
    send_byte({4'b0101, 4'hB}, ka);
    send_byte({4'b1011, 2'b10, 2'b01}, ki);
    check("R8 read instruction ack", int'(ki), 1);
    recv_byte(1'b1, rb);
    check("R8 first read byte", int'(rb), int'(8'(8'h5A + 8'(snap_l))));
    recv_byte(1'b1, rb);
    check("R9 second read byte after ack", int'(rb), int'(8'(8'h5A + 8'(snap_l + 1))));
    recv_byte(1'b0, rb);
    check("R9 third read byte", int'(rb), int'(8'(8'h5A + 8'(snap_l + 2))));
    recv_byte(1'b0, rb);
    check("R9 line released after master nack", int'(rb), 8'hFF);
    bus_stop();
    check("R9 loads requested", n_load - snap_l, 3);

    // R1: STOP ends selection; bytes after it are ignored
    snap_i = n_instr;
    bus_start(); send_byte({4'b0101, 4'hB}, ka); bus_stop();
    send_byte(8'hA1, ki);
    check("R1 byte after STOP nack", int'(ki), 0);
    check("R1 no instruction after STOP", n_instr - snap_i, 0);
    bus_stop();

    // R1: repeated START in the middle of an address byte
    bus_start();
    begin
      logic s;
      clk_bit(1'b0, s); clk_bit(1'b1, s); clk_bit(1'b0, s); clk_bit(1'b1, s);
    end
    xfer3({4'b0101, 4'hB}, {4'b1010, 2'b00, 2'b00}, 8'h96, ka, ki, kd);
    check("R1 restart address ack", int'(ka), 1);
    check("R1 restart data ack", int'(kd), 1);
    check("R1 restart data value", int'(data), 8'h96);

    // Random writes, with some address corruption
    for (int it = 0; it < 16; it++) begin
      logic [3:0] op;
      logic bad;
      strap = 4'($urandom);
      wp_n  = 1'($urandom);
      op    = ($urandom % 3 == 0) ? 4'b1010 : 4'b1100;
      ins   = {op, 2'($urandom), 2'($urandom)};
      d     = 8'($urandom);
      addr  = {4'b0101, strap};
      bad   = (it % 5 == 4);
      if (bad) addr = addr ^ (8'd1 << ($urandom % 8));
      snap_d = n_data;
      xfer3(addr, ins, d, ka, ki, kd);
      if (bad) begin
        check("R2 random mismatch nack", int'(ka | ki | kd), 0);
      end else begin
        check("R2 random address ack", int'(ka), 1);
        check("R5 random opcode", int'(opcode), int'(op));
        check(op == 4'b1100 ? "R7 random guarded data ack" : "R6 random data ack",
              int'(kd), int'(exp_data_ack(op, wp_n)));
        check("R6 random data strobe count", n_data - snap_d, int'(exp_data_ack(op, wp_n)));
        if (exp_data_ack(op, wp_n)) check("R6 random data value", int'(data), int'(d));
      end
    end

    check("R3 no drive change while clock high", unstable, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule